// File: doc/BRIEF.md
# SD Card Bus Clock Divider

This block derives the SD card bus clock from a faster base clock. Software writes one 32-bit control word. The word holds a power-of-two prescaler code, a linear divisor code, three clock-enable bits and a data-timeout exponent. The divided clock is produced by a small state machine. The machine counts half periods of the base clock and drives a registered output, so the output never carries a combinational glitch.

The machine has four states. OFF holds the output low while the card-clock enable is clear. SETTLE holds the output low for one new half period after an enable or a divider change. HIGH and LOW alternate to form the running clock. The transitions are:
- OFF to SETTLE when the enable rises.
- SETTLE to HIGH at the end of its half period.
- HIGH to LOW at the end of the high half.
- HIGH to SETTLE at the end of the high half when a divider change is pending.
- LOW to HIGH at the end of the low half.
- LOW to SETTLE immediately on a divider change.
- SETTLE to SETTLE, restarting the count, on a divider change.
- Any state to OFF when the enable clears.

A stable flag reports that one complete output period has passed since the last divider change. The timeout exponent is passed on, saturated, to a separate data-timeout counter.

Top module: `sdclk_divider`

## Requirements
- R1: After reset the card clock is 0, the stable flag is 0, the register reads 0 and the timeout exponent is 0.
- R2: A write stores the full 32-bit word, and the word reads back on `sysctl_q` from the cycle after the write.
- R3: While bit 2 (card-clock enable) is 0, the card clock is held low and the stable flag is 0.
- R4: With the enable set, each high half and each low half of the card clock lasts H base cycles. H = P/2 × D, where P is the prescale value and D = bits 7:4 + 1 (1 to 16). The card frequency is therefore base / (P × D).
- R5: Bits 15:8 hold the prescaler code, and P = 2 × code for power-of-two codes 1 to 128. A code that is not a power of two counts as its highest set bit. A code of 0 counts as 1.
- R6: A write that changes bits 15:4 never shortens a high half. A change during a high half lets that half finish at its old length. The output then stays low for exactly one new half period before the first new rising edge.
- R7: The stable flag clears in the second cycle after a write that changes bits 15:4. It sets again when the first complete output period after that change ends.
- R8: The timeout exponent output equals bits 19:16, except that a value of 15 is reported as 14.
- R9: A write that leaves bits 15:4 and bit 2 unchanged does not disturb the card clock phase or the stable flag. Such a write may change bits 1:0 (host and interface enables) or the timeout field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysctl_wr | input | 1 | Control word write strobe |
| sysctl_wdata | input | 32 | Control word write data |
| sysctl_q | output | 32 | Current control word |
| card_clk | output | 1 | Divided card bus clock |
| clk_stable | output | 1 | One full period has elapsed since the last divider change |
| tout_exp | output | 4 | Saturated data-timeout exponent |

## Verification
The R7 and R9 properties assume that writes are never issued on two consecutive cycles. Under that assumption, a divider change is never hidden behind a second write before the state machine has reacted to it. The stimulus always leaves at least one idle cycle between writes. Every write is driven on a falling edge and released on the next falling edge. Divider changes are placed deliberately inside a high half, to exercise the pending-change path, and elsewhere while the clock is running or settling.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int REG_W      = 32;
    localparam int PRE_LSB    = 8;
    localparam int PRE_W      = 8;
    localparam int DIV_LSB    = 4;
    localparam int DIV_W      = 4;
    localparam int TOUT_LSB   = 16;
    localparam int TOUT_W     = 4;
    localparam int TOUT_MAX   = 14;
    localparam int RUN_BIT    = 2;
    localparam int HALF_W     = PRE_W + DIV_W;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SETTLE,
        ST_HIGH,
        ST_LOW
    } sdclk_state_e;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
    import sdclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     cfg_q,
    output logic                 div_chg_q,
    output logic [TOUT_W-1:0]    tout_exp
);
    localparam int FLD_HI = PRE_LSB + PRE_W - 1;

    logic fld_diff;
    logic [TOUT_W-1:0] tout_raw;

    assign fld_diff = (wr_data[FLD_HI:DIV_LSB] != cfg_q[FLD_HI:DIV_LSB]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            div_chg_q <= 1'b0;
        end else begin
            div_chg_q <= wr_en && fld_diff;
            if (wr_en) begin
                cfg_q <= wr_data;
            end
        end
    end

    assign tout_raw = cfg_q[TOUT_LSB +: TOUT_W];

    always_comb begin
        if (tout_raw > TOUT_W'(TOUT_MAX)) begin
            tout_exp = TOUT_W'(TOUT_MAX);
        end else begin
            tout_exp = tout_raw;
        end
    end
endmodule

// File: rtl/sdclk_half_calc.sv
module sdclk_half_calc
    import sdclk_pkg::*;
(
    input  logic [PRE_W-1:0]  pre_code,
    input  logic [DIV_W-1:0]  div_code,
    output logic [HALF_W-1:0] half_len
);
    localparam int SH_W = $clog2(PRE_W);

    logic [SH_W-1:0]   top_bit;
    logic [HALF_W-1:0] lin_val;

    // highest set bit of the prescaler code; a zero code acts as 1
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (pre_code[i]) begin
                top_bit = SH_W'(i);
            end
        end
    end

    assign lin_val  = HALF_W'(div_code) + HALF_W'(1);
    assign half_len = lin_val << top_bit;
endmodule

// File: rtl/sdclk_gen_fsm.sv
module sdclk_gen_fsm
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              div_chg,
    input  logic [HALF_W-1:0] half_cfg,
    output logic              card_clk,
    output logic              clk_stable
);
    sdclk_state_e      state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] hact_q, hact_d;
    logic              pend_q, pend_d;
    logic              last;
    logic              clk_q, stab_q;

    assign last = (cnt_q == hact_q - HALF_W'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hact_d  = hact_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en) begin
                    state_d = ST_SETTLE;
                    hact_d  = half_cfg;
                    cnt_d   = '0;
                    pend_d  = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (div_chg) begin
                    hact_d = half_cfg;
                    cnt_d  = '0;
                end else if (last) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            ST_HIGH: begin
                if (last) begin
                    cnt_d = '0;
                    if (pend_q || div_chg) begin
                        state_d = ST_SETTLE;
                        hact_d  = half_cfg;
                        pend_d  = 1'b0;
                    end else begin
                        state_d = ST_LOW;
                    end
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                    if (div_chg) begin
                        pend_d = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (div_chg) begin
                    state_d = ST_SETTLE;
                    hact_d  = half_cfg;
                    cnt_d   = '0;
                end else if (last) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + HALF_W'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
        if (!run_en) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            pend_d  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            hact_q  <= HALF_W'(1);
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hact_q  <= hact_d;
            pend_q  <= pend_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            clk_q <= (state_d == ST_HIGH);
            if (state_d == ST_OFF || div_chg) begin
                stab_q <= 1'b0;
            end else if (state_q == ST_LOW && last) begin
                stab_q <= 1'b1;
            end
        end
    end

    assign card_clk   = clk_q;
    assign clk_stable = stab_q;
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysctl_wr,
    input  logic [REG_W-1:0]  sysctl_wdata,
    output logic [REG_W-1:0]  sysctl_q,
    output logic              card_clk,
    output logic              clk_stable,
    output logic [TOUT_W-1:0] tout_exp
);
    logic              div_chg;
    logic [HALF_W-1:0] half_cfg;

    sdclk_cfg_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sysctl_wr),
        .wr_data   (sysctl_wdata),
        .cfg_q     (sysctl_q),
        .div_chg_q (div_chg),
        .tout_exp  (tout_exp)
    );

    sdclk_half_calc u_half (
        .pre_code (sysctl_q[PRE_LSB +: PRE_W]),
        .div_code (sysctl_q[DIV_LSB +: DIV_W]),
        .half_len (half_cfg)
    );

    sdclk_gen_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (sysctl_q[RUN_BIT]),
        .div_chg    (div_chg),
        .half_cfg   (half_cfg),
        .card_clk   (card_clk),
        .clk_stable (clk_stable)
    );
endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk
    import sdclk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sysctl_wr,
    input logic [REG_W-1:0]  sysctl_wdata,
    input logic [REG_W-1:0]  sysctl_q,
    input logic              card_clk,
    input logic              clk_stable,
    input logic [TOUT_W-1:0] tout_exp
);
    localparam int FLD_HI = PRE_LSB + PRE_W - 1;

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysctl_wr |=> sysctl_q == $past(sysctl_wdata));

    // R3
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sysctl_q[RUN_BIT] |=> !card_clk);

    // R3
    off_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sysctl_q[RUN_BIT] |=> !clk_stable);

    // R7
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sysctl_wr && sysctl_wdata[FLD_HI:DIV_LSB] != sysctl_q[FLD_HI:DIV_LSB])
        |=> ##1 !clk_stable);

    // R8
    tout_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout_exp <= TOUT_W'(TOUT_MAX));

    // R9
    keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sysctl_wr && !$past(sysctl_wr) && clk_stable && sysctl_q[RUN_BIT]
         && sysctl_wdata[RUN_BIT]
         && sysctl_wdata[FLD_HI:DIV_LSB] == sysctl_q[FLD_HI:DIV_LSB])
        |=> ##1 clk_stable);
endmodule

bind sdclk_divider sdclk_divider_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sysctl_wr    (sysctl_wr),
    .sysctl_wdata (sysctl_wdata),
    .sysctl_q     (sysctl_q),
    .card_clk     (card_clk),
    .clk_stable   (clk_stable),
    .tout_exp     (tout_exp)
);

// File: tb/sdclk_divider_test.sv
module sdclk_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] sysctl_q;
    logic        card_clk;
    logic        clk_stable;
    logic [3:0]  tout_exp;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sdclk_divider uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sysctl_wr    (wr),
        .sysctl_wdata (wd),
        .sysctl_q     (sysctl_q),
        .card_clk     (card_clk),
        .clk_stable   (clk_stable),
        .tout_exp     (tout_exp)
    );

    localparam int NVEC = 7;
    localparam logic [31:0] VW [NVEC] = '{
        32'h0003_0104, 32'h000E_0234, 32'h000F_80F4, 32'h0000_0424,
        32'h0005_0014, 32'h0000_0614, 32'h0007_1044};
    localparam int VH [NVEC] = '{1, 8, 2048, 12, 2, 8, 80};
    localparam int VT [NVEC] = '{3, 14, 14, 0, 5, 0, 7};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic write_reg(input logic [31:0] w);
        wr = 1'b1;
        wd = w;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_stable();
        int n = 0;
        while (!clk_stable && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // returns at the first falling edge where card_clk is seen high after low
    task automatic wait_rise();
        int n = 0;
        while (card_clk && n < 10000) begin
            @(negedge clk);
            n++;
        end
        while (!card_clk && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (card_clk && hi < 10000) begin
            hi++;
            @(negedge clk);
        end
        while (!card_clk && lo < 10000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        check(card_clk == 1'b0, "R1 clk", card_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(card_clk == 1'b0 && clk_stable == 1'b0, "R1 clk/stable", {card_clk, clk_stable}, 0);
        check(sysctl_q == 32'h0, "R1 reg", sysctl_q, 0);
        check(tout_exp == 4'h0, "R1 tout", tout_exp, 0);
        repeat (5) @(negedge clk);
        check(card_clk == 1'b0, "R3 idle low", card_clk, 0);

        // table of settings: R4, R5, R8, R2, R7
        for (int i = 0; i < NVEC; i++) begin
            write_reg(VW[i]);
            check(sysctl_q == VW[i], "R2 readback", sysctl_q, VW[i]);
            @(negedge clk);
            check(clk_stable == 1'b0, "R7 cleared", clk_stable, 0);
            check(int'(tout_exp) == VT[i], "R8 tout", tout_exp, VT[i]);
            wait_stable();
            check(clk_stable == 1'b1, "R7 set", clk_stable, 1);
            wait_rise();
            measure(hi, lo);
            check(hi == VH[i], "R4 R5 high half", hi, VH[i]);
            check(lo == VH[i], "R4 R5 low half", lo, VH[i]);
        end

        // R6: change during a high half (H 8 -> 3)
        write_reg(32'h0000_0234);
        wait_stable();
        wait_rise();
        hi = 1;
        wr = 1'b1;
        wd = 32'h0000_0124;
        @(negedge clk);
        wr = 1'b0;
        while (card_clk && hi < 10000) begin
            hi++;
            @(negedge clk);
        end
        check(hi == 8, "R6 old high kept", hi, 8);
        check(clk_stable == 1'b0, "R7 cleared mid", clk_stable, 0);
        lo = 0;
        while (!card_clk && lo < 10000) begin
            lo++;
            @(negedge clk);
        end
        check(lo == 3, "R6 settle low", lo, 3);
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R6 new halves", hi, 3);
        wait_stable();
        check(clk_stable == 1'b1, "R7 set after change", clk_stable, 1);

        // R9: same divider fields, other bits changed
        wait_rise();
        write_reg(32'h000F_0127);
        for (int k = 0; k < 30; k++) begin
            if (!clk_stable) check(1'b0, "R9 stable kept", clk_stable, 1);
            @(negedge clk);
        end
        check(clk_stable == 1'b1, "R9 stable kept", clk_stable, 1);
        check(tout_exp == 4'd14, "R8 saturate", tout_exp, 14);
        wait_rise();
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R9 period kept", hi, 3);

        // R3: disable holds clock low
        write_reg(32'h0000_0123);
        @(negedge clk);
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                if (card_clk || clk_stable) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R3 held low", seen, 0);
        end
        write_reg(32'h0000_0124);
        wait_stable();
        wait_rise();
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R3 restart", hi, 3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule